// File: doc/BRIEF.md
# Two-B-Channel Time-Slot Interface

This block sits between a byte-oriented voice datapath and a serial time-slot bus of the kind used for ISDN basic-rate framing. A frame pulse and a data clock set the timing. Each frame holds two consecutive 16-clock B-channel slots: the first slot is B1 and the second is B2. Each bit lasts two data-clock cycles, so the bit rate is half the clock rate. A channel-select input picks one slot. In that slot the block shifts out one byte and collects one byte, both MSB first.

The interface is only active once a separate mode detector has seen a monitored clock input held low through two whole frames. A single sampled high level on that input drops the mode again. Outside the selected slot, and whenever the mode is off, the serial output is not driven. Frame timing comes from a slot counter. Every rising edge of the frame pulse restarts that counter.

Top module: `gci_bchan_if`

## Requirements
- R1: While reset is asserted, tx_en, tx_out, rx_valid and gci_mode are all 0.
- R2: gci_mode rises at the third frame-pulse rising edge seen while the synchronised monitor input stays low without a break. This is the edge that closes the second whole low frame. gci_mode is visible in that edge's clock cycle, which is cycle 0 of the new frame.
- R3: The monitor input is sampled high and passes the SYNC_STAGES-deep synchroniser. gci_mode is then 0 from the second clock cycle after the one in which the high level was presented, and the count of low frames restarts from zero.
- R4: A clock edge where fsync is 1 and was 0 at the previous edge makes the cycle it starts cycle 0 of a frame. fsync staying high restarts nothing, and a rising edge in the middle of a frame restarts the count at once.
- R5: chan_sel is sampled only at the frame-start edge, with 0 selecting B1 and 1 selecting B2. B1 occupies frame cycles 0 to 15 and B2 occupies cycles 16 to 31. While gci_mode is set, tx_en is 1 in exactly the 16 cycles of the selected slot.
- R6: tx_byte is sampled only at the frame-start edge. During slot cycles 2k and 2k+1, tx_out carries bit 7-k of that byte, MSB first. tx_out is 0 whenever tx_en is 0.
- R7: Each received bit is taken from rx_in at the edge that opens the second cycle of its two-cycle bit period, which is the midpoint of the bit. The value rx_in holds in the first cycle of the bit period is ignored. Bits assemble MSB first.
- R8: rx_valid is high for one cycle, in slot cycle 15 of the selected slot, and rx_byte then holds the received byte. Data in the other slot has no effect on rx_byte or rx_valid.
- R9: Without a frame pulse, the slot counter stops at 2^CNT_W-1 and does not wrap back into a slot.
- R10: While gci_mode is 0, tx_en and rx_valid stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame pulse; its rising edge marks frame cycle 0 |
| chan_sel | input | 1 | Slot select, 0 = B1, 1 = B2 |
| mon_clk | input | 1 | Monitored clock input used for mode detection |
| tx_byte | input | BITS | Byte to send in the selected slot |
| rx_in | input | 1 | Serial receive data |
| tx_out | output | 1 | Serial transmit data |
| tx_en | output | 1 | Transmit drive enable |
| rx_byte | output | BITS | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| gci_mode | output | 1 | Interface mode active |

## Verification
A slot counter that is off by one shows within a single frame. tx_en opens or closes a cycle early or late, and the transmitted bit pairs straddle bit boundaries. A wrong frame count in the mode detector shows up as gci_mode rising one frame too early or too late, so every frame in the entry and re-entry sequences checks the flag in every cycle. A receive sampling phase that is off by one cycle corrupts rx_byte at the strobe of the very next slot, because the stimulus puts the inverted bit in the first cycle of each bit period. A counter that wraps instead of holding shows as a stray enable more than 256 cycles into a frame with no frame pulse.

// File: rtl/gci_pkg.sv
package gci_pkg;

    typedef enum logic {
        CH_FIRST  = 1'b0,
        CH_SECOND = 1'b1
    } chan_e;

endpackage

// File: rtl/gci_sync.sv
module gci_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign sh_d[i] = din;
        end else begin : g_tail
            assign sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/gci_frame_timer.sv
module gci_frame_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic             frame_start,
    output logic [CNT_W-1:0] cnt_next
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             fs_prev;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d;
    tmr_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.fs_prev = fsync;
        frame_start  = fsync && !st_q.fs_prev;
        if (frame_start) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fs_prev <= 1'b1;
            st_q.cnt     <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_next = st_d.cnt;

endmodule

// File: rtl/gci_mode_detect.sv
module gci_mode_detect #(
    parameter int LOW_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_s,
    input  logic frame_start,
    output logic mode_next,
    output logic mode
);

    localparam int CW = $clog2(LOW_FRAMES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOW_FRAMES);

    typedef struct packed {
        logic [CW-1:0] edges;
        logic          active;
    } det_t;

    det_t st_d;
    det_t st_q;

    always_comb begin
        st_d = st_q;
        if (mon_s) begin
            st_d.edges  = '0;
            st_d.active = 1'b0;
        end else if (frame_start) begin
            if (st_q.edges == LIMIT) begin
                st_d.active = 1'b1;
            end else begin
                st_d.edges = st_q.edges + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_next = st_d.active;
    assign mode      = st_q.active;

endmodule

// File: rtl/gci_bchan_path.sv
module gci_bchan_path
    import gci_pkg::*;
#(
    parameter int BITS         = 8,
    parameter int CLKS_PER_BIT = 2,
    parameter int CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             mode_next,
    input  logic             chan_sel,
    input  logic [BITS-1:0]  tx_byte,
    input  logic             rx_in,
    output logic             tx_out,
    output logic             tx_en,
    output logic [BITS-1:0]  rx_byte,
    output logic             rx_valid
);

    localparam int SLOT_CLKS = BITS * CLKS_PER_BIT;
    localparam int BIT_W     = $clog2(BITS);
    localparam int SAMPLE_PH = CLKS_PER_BIT / 2;
    localparam logic [CNT_W-1:0] SLOT_LEN = CNT_W'(SLOT_CLKS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

    typedef struct packed {
        chan_e           sel;
        logic [BITS-1:0] word;
        logic [BITS-1:0] shreg;
        logic            tx_out;
        logic            tx_en;
        logic [BITS-1:0] rx_byte;
        logic            rx_valid;
    } path_t;

    path_t st_d;
    path_t st_q;

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] off;
    logic [BIT_W-1:0] bitk;
    logic             in_slot;
    logic             sample;

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = 1'b0;

        if (frame_start) begin
            st_d.sel  = chan_e'(chan_sel);
            st_d.word = tx_byte;
        end

        base    = (st_d.sel == CH_SECOND) ? SLOT_LEN : '0;
        off     = cnt_next - base;
        in_slot = mode_next && (cnt_next >= base) && (off < SLOT_LEN);
        bitk    = BIT_W'(off / CNT_W'(CLKS_PER_BIT));
        sample  = (off % CNT_W'(CLKS_PER_BIT)) == CNT_W'(SAMPLE_PH);

        st_d.tx_en  = in_slot;
        st_d.tx_out = in_slot ? st_d.word[LAST_BIT - bitk] : 1'b0;

        if (in_slot && sample) begin
            st_d.shreg = {st_q.shreg[BITS-2:0], rx_in};
            if (bitk == LAST_BIT) begin
                st_d.rx_byte  = st_d.shreg;
                st_d.rx_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_out   = st_q.tx_out;
    assign tx_en    = st_q.tx_en;
    assign rx_byte  = st_q.rx_byte;
    assign rx_valid = st_q.rx_valid;

endmodule

// File: rtl/gci_bchan_if.sv
module gci_bchan_if #(
    parameter int BITS         = 8,
    parameter int CLKS_PER_BIT = 2,
    parameter int CNT_W        = 8,
    parameter int LOW_FRAMES   = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fsync,
    input  logic            chan_sel,
    input  logic            mon_clk,
    input  logic [BITS-1:0] tx_byte,
    input  logic            rx_in,
    output logic            tx_out,
    output logic            tx_en,
    output logic [BITS-1:0] rx_byte,
    output logic            rx_valid,
    output logic            gci_mode
);

    logic             mon_s;
    logic             frame_start;
    logic [CNT_W-1:0] cnt_next;
    logic             mode_next;

    gci_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mon_clk),
        .dout  (mon_s)
    );

    gci_frame_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync       (fsync),
        .frame_start (frame_start),
        .cnt_next    (cnt_next)
    );

    gci_mode_detect #(
        .LOW_FRAMES (LOW_FRAMES)
    ) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .mon_s       (mon_s),
        .frame_start (frame_start),
        .mode_next   (mode_next),
        .mode        (gci_mode)
    );

    gci_bchan_path #(
        .BITS         (BITS),
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .CNT_W        (CNT_W)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cnt_next    (cnt_next),
        .mode_next   (mode_next),
        .chan_sel    (chan_sel),
        .tx_byte     (tx_byte),
        .rx_in       (rx_in),
        .tx_out      (tx_out),
        .tx_en       (tx_en),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid)
    );

endmodule

// File: rtl/gci_bchan_if_chk.sv
module gci_bchan_if_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic tx_out,
    input logic rx_valid,
    input logic gci_mode,
    input logic mon_s,
    input logic frame_start
);

    // R1: outputs held quiet during reset
    a_r1_reset_quiet: assert property (@(negedge clk)
        !rst_n |-> (!tx_en && !tx_out && !rx_valid && !gci_mode));

    // R2: mode only rises after a frame edge with the monitor low
    a_r2_entry_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gci_mode) |-> ($past(frame_start) && !$past(mon_s)));

    // R3: a synchronised high level drops the mode on the next edge
    a_r3_exit_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        mon_s |=> !gci_mode);

    // R6: no data on the line while the driver is off
    a_r6_out_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_out);

    // R8: strobe lasts one cycle
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: no slot activity without the mode
    a_r10_tx_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> gci_mode);

    a_r10_rx_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> gci_mode);

endmodule

bind gci_bchan_if gci_bchan_if_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .tx_out      (tx_out),
    .rx_valid    (rx_valid),
    .gci_mode    (gci_mode),
    .mon_s       (mon_s),
    .frame_start (frame_start)
);

// File: tb/gci_bchan_if_test.sv
module gci_bchan_if_test;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       chan_sel = 1'b0;
    logic       mon_clk = 1'b1;
    logic [7:0] tx_byte = '0;
    logic       rx_in = 1'b0;
    logic       tx_out;
    logic       tx_en;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       gci_mode;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  mon_hold_low = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gci_bchan_if uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .chan_sel (chan_sel),
        .mon_clk  (mon_clk),
        .tx_byte  (tx_byte),
        .rx_in    (rx_in),
        .tx_out   (tx_out),
        .tx_en    (tx_en),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .gci_mode (gci_mode)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit in_slot(input int c, input logic sel);
        int base = sel ? 16 : 0;
        return (c >= base) && (c < base + 16);
    endfunction

    function automatic logic exp_tx_bit(input int c, input logic sel, input logic [7:0] b);
        int off = c - (sel ? 16 : 0);
        return b[7 - off/2];
    endfunction

    function automatic logic rx_drive(input int c, input logic sel, input logic [7:0] b,
                                      input logic [7:0] other, input logic midtest);
        int   slot;
        int   off;
        logic [7:0] v;
        logic bitv;
        if (c >= 32) return 1'($urandom);
        slot = c / 16;
        off  = c % 16;
        v    = (slot == int'(sel)) ? b : other;
        bitv = v[7 - off/2];
        if (midtest && (off % 2 == 0)) bitv = ~bitv;
        return bitv;
    endfunction

    // ev_kind: 0 none, 1 monitor held low from ev_at, 2 one-cycle high pulse at ev_at
    task automatic run_frame(input int len, input int fs_len, input logic sel,
                             input logic [7:0] txb, input logic [7:0] rxb,
                             input logic m_exp, input logic midtest,
                             input int ev_at, input int ev_kind,
                             input string tag, input string mtag);
        logic [7:0] other = 8'($urandom);
        for (int c = 0; c < len; c++) begin
            logic m;
            bit   slot;
            string rq;
            @(negedge clk);
            fsync = (c < fs_len);
            if (c == 0) begin
                chan_sel = sel;
                tx_byte  = txb;
            end else begin
                chan_sel = 1'($urandom);
                tx_byte  = 8'($urandom);
            end
            if (ev_kind == 1 && c == ev_at) mon_hold_low = 1'b1;
            if (ev_kind == 2 && c == ev_at) mon_clk = 1'b1;
            else mon_clk = mon_hold_low ? 1'b0 : ~mon_clk;
            rx_in = rx_drive(c, sel, rxb, other, midtest);
            @(posedge clk);
            #(CLK_PERIOD/4);
            m = m_exp;
            if (ev_kind == 2 && c >= ev_at + 2) m = 1'b0;
            slot = in_slot(c, sel);
            check(mtag, "gci_mode", int'(gci_mode), int'(m));
            rq = (tag != "") ? tag : (m ? "R5" : "R10");
            check(rq, "tx_en", int'(tx_en), int'(m && slot));
            check(m ? "R6" : "R10", "tx_out", int'(tx_out),
                  int'((m && slot) ? exp_tx_bit(c, sel, txb) : 1'b0));
            check(m ? "R8" : "R10", "rx_valid", int'(rx_valid),
                  int'(m && (c == (sel ? 16 : 0) + 15)));
            if (m && rx_valid) check("R7", "rx_byte", int'(rx_byte), int'(rxb));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_61C1));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "tx_en", int'(tx_en), 0);
        check("R1", "tx_out", int'(tx_out), 0);
        check("R1", "rx_valid", int'(rx_valid), 0);
        check("R1", "gci_mode", int'(gci_mode), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: monitor toggling, interface stays idle
        run_frame(FRAME, 1, 1'b0, 8'hA5, 8'h5A, 1'b0, 1'b0, 0, 0, "", "R10");
        run_frame(FRAME, 1, 1'b1, 8'hC3, 8'h3C, 1'b0, 1'b0, 40, 1, "", "R10");
        // R2: two whole low frames before entry
        run_frame(FRAME, 1, 1'b0, 8'hFF, 8'h81, 1'b0, 1'b0, 0, 0, "", "R2");
        run_frame(FRAME, 1, 1'b1, 8'h0F, 8'hF0, 1'b0, 1'b0, 0, 0, "", "R2");
        run_frame(FRAME, 1, 1'b0, 8'hA5, 8'h96, 1'b1, 1'b0, 0, 0, "", "R2");

        // R5/R6/R7: directed bytes on both slots, MSB-first corners
        run_frame(FRAME, 1, 1'b1, 8'h3C, 8'h69, 1'b1, 1'b0, 0, 0, "", "R2");
        run_frame(FRAME, 1, 1'b0, 8'h80, 8'h01, 1'b1, 1'b1, 0, 0, "", "R2");
        run_frame(FRAME, 1, 1'b1, 8'h01, 8'h80, 1'b1, 1'b1, 0, 0, "", "R2");
        // R4: long frame pulse does not restart the count
        run_frame(FRAME, 3, 1'b0, 8'hB7, 8'h4D, 1'b1, 1'b1, 0, 0, "R4", "R2");
        run_frame(FRAME, 20, 1'b1, 8'h6E, 8'hD2, 1'b1, 1'b0, 0, 0, "R4", "R2");

        // random frames
        for (int i = 0; i < 40; i++) begin
            run_frame(FRAME, 1 + int'($urandom % 4), 1'($urandom), 8'($urandom),
                      8'($urandom), 1'b1, 1'($urandom), 0, 0, "", "R2");
        end

        // R4: frame pulse mid-slot restarts the count
        run_frame(20, 1, 1'b1, 8'hE4, 8'h27, 1'b1, 1'b0, 0, 0, "R4", "R2");
        run_frame(FRAME, 1, 1'b1, 8'h1B, 8'hC6, 1'b1, 1'b1, 0, 0, "R4", "R2");

        // R9: long gap without a frame pulse
        run_frame(300, 1, 1'b0, 8'h55, 8'hAA, 1'b1, 1'b0, 0, 0, "R9", "R9");

        // R3: single high sample drops the mode, then re-entry after two low frames
        run_frame(FRAME, 1, 1'b0, 8'h99, 8'h66, 1'b1, 1'b0, 40, 2, "", "R3");
        run_frame(FRAME, 1, 1'b0, 8'h12, 8'h34, 1'b0, 1'b0, 0, 0, "", "R3");
        run_frame(FRAME, 1, 1'b1, 8'h56, 8'h78, 1'b0, 1'b0, 0, 0, "", "R3");
        run_frame(FRAME, 1, 1'b1, 8'h9A, 8'hBC, 1'b1, 1'b1, 0, 0, "", "R2");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule